// File: doc/BRIEF.md
# Bisection Drive Geometry Prober

This block discovers the geometry of an unknown drive (head count, cylinder count and sectors per track) without any table of known drive types. It sends seek commands to the drive and watches which ones succeed. Each dimension is searched by bisection between a lower bound that is known to work and an upper bound that is known to fail. The three dimensions are searched one after another. A value found for an earlier dimension stays fixed in all later seeks. Dimensions not yet searched are sent as zero.

The block drives a command request port: a one-cycle request pulse together with an opcode and head, cylinder and sector fields. It then waits for a response strobe that carries a success flag and a transport timeout flag. The command transport itself is outside the block. When the last dimension has converged, the block presents each dimension as the largest accepted value plus one, presents a zero control byte, and raises done. Done stays high until the next start.

Top module: `geom_prober`

## Requirements
- R1: After reset, done, busy and the request pulse are all low, and no request is issued until start is seen.
- R2: Every request carries opcode 0x0B. Heads are searched first, with the cylinder and sector fields at 0. Cylinders are searched next, with head fixed at the found head count minus one and sector at 0. Sectors are searched last, with head and cylinder both fixed at their found values minus one.
- R3: Each probe value is floor((low+high)/2) of the current bounds. The initial bounds are low 0 and high 16, 1024 and 64 for heads, cylinders and sectors. So the first probes are head 8, cylinder 512 and sector 32.
- R4: An accepted seek sets low to the probe value. A rejected seek sets high to the probe value. A dimension ends when low equals high−1. With the default limits a full search therefore issues exactly 4+10+6 = 20 requests.
- R5: Once done, each geometry output equals that dimension's final low bound plus one, and the control byte output is 0.
- R6: A response that has the timeout flag set counts as a rejection, even when its success flag is high.
- R7: The request strobe lasts exactly one cycle. The next request is issued only after a response to the previous one, and the request fields stay stable while the response is awaited.
- R8: A start pulse while busy, and a response strobe while no request is outstanding, have no effect on the search, the geometry or the request stream.
- R9: Done and the geometry hold until the next start. A new start clears done and searches again from the initial bounds.
- R10: A drive that rejects every seek is reported as 1 head, 1 cylinder and 1 sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a geometry search (taken when idle or done) |
| req_valid_o | output | 1 | One-cycle command request strobe |
| req_opcode_o | output | 8 | Command opcode (seek, 0x0B) |
| req_head_o | output | $clog2(HEAD_LIMIT+1) | Head field of the request |
| req_cyl_o | output | $clog2(CYL_LIMIT+1) | Cylinder field of the request |
| req_sec_o | output | $clog2(SEC_LIMIT+1) | Sector field of the request |
| rsp_valid_i | input | 1 | Response strobe for the outstanding request |
| rsp_ok_i | input | 1 | Seek succeeded |
| rsp_timeout_i | input | 1 | Transport timed out (treated as failure) |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished, geometry valid |
| geo_heads_o | output | $clog2(HEAD_LIMIT+1) | Number of heads found |
| geo_cyls_o | output | $clog2(CYL_LIMIT+1) | Number of cylinders found |
| geo_secs_o | output | $clog2(SEC_LIMIT+1) | Sectors per track found |
| geo_ctrl_o | output | 8 | Control byte for the drive, always 0 |

## Verification
The bench models a drive that accepts a seek only when the head, cylinder and sector are all below a hidden geometry. It sweeps every head count from 0 to beyond the limit. It then sweeps cylinder and sector counts around the powers of two and the limits, so that off-by-one errors at either end of a bisection show up as a wrong count. Hidden geometries with a zero dimension, and responses that carry the timeout flag with success also high, both must yield 1/1/1. This separates rejection handling from acceptance handling. Per-request checks on the fixed fields, the first two probe values and the request count tell a wrong search order, a wrong midpoint or a wrong convergence test apart from a wrong final offset. Start pulses during a search and stray response strobes after one are used to show that both are ignored.

// File: rtl/geom_probe_pkg.sv
package geom_probe_pkg;

  // sequencer states
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_CHECK,
    PS_ISSUE,
    PS_WAIT,
    PS_FIX,
    PS_DONE
  } probe_state_e;

  localparam int NUM_AXES = 3;
  localparam int AXIS_W   = 2;

  typedef logic [AXIS_W-1:0] axis_idx_t;

  // axis numbering also fixes the search order: heads, cylinders, sectors
  localparam axis_idx_t AX_HEAD = 2'd0;
  localparam axis_idx_t AX_CYL  = 2'd1;
  localparam axis_idx_t AX_SEC  = 2'd2;

  localparam logic [7:0] SEEK_OPCODE = 8'h0B;

endpackage

// File: rtl/bisect_axis.sv
module bisect_axis #(
  parameter int MAXV = 16,
  parameter int BW   = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          sel_i,
  input  logic          step_i,
  input  logic          upd_i,
  input  logic          ok_i,
  input  logic          fix_i,
  output logic [BW-1:0] probe_o,
  output logic [BW-1:0] low_o,
  output logic          conv_o
);

  localparam logic [BW-1:0] TOP = BW'(MAXV);
  localparam logic [BW-1:0] ONE = BW'(1);

  logic [BW-1:0] lo_q, lo_d;
  logic [BW-1:0] hi_q, hi_d;
  logic [BW-1:0] pr_q, pr_d;
  logic [BW:0]   sum_w;
  logic [BW-1:0] mid_w;
  logic          en_w;

  assign sum_w = {1'b0, lo_q} + {1'b0, hi_q};
  assign mid_w = BW'(sum_w >> 1);
  assign en_w  = init_i | (sel_i & (step_i | upd_i | fix_i));

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    pr_d = pr_q;
    if (init_i) begin
      lo_d = '0;
      hi_d = TOP;
      pr_d = '0;
    end else if (sel_i) begin
      if (step_i) pr_d = mid_w;
      if (upd_i) begin
        if (ok_i) lo_d = pr_q;
        else      hi_d = pr_q;
      end
      if (fix_i) pr_d = lo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= TOP;
      pr_q <= '0;
    end else if (en_w) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      pr_q <= pr_d;
    end
  end

  assign probe_o = pr_q;
  assign low_o   = lo_q;
  assign conv_o  = ((lo_q + ONE) == hi_q);

  // R4: the known-good bound always stays below the known-bad bound
  p_bounds_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q < hi_q);

  // R4: outside a restart the bounds only close in
  p_bounds_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i |=> (lo_q >= $past(lo_q)) && (hi_q <= $past(hi_q)));

endmodule

// File: rtl/probe_sequencer.sv
module probe_sequencer
  import geom_probe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                rsp_valid_i,
  input  logic [NUM_AXES-1:0] conv_i,
  output axis_idx_t           axis_o,
  output logic                init_o,
  output logic                step_o,
  output logic                upd_o,
  output logic                fix_o,
  output logic                req_o,
  output logic                busy_o,
  output logic                done_o
);

  localparam axis_idx_t LAST_AXIS = axis_idx_t'(NUM_AXES - 1);

  probe_state_e state_q, state_d;
  axis_idx_t    axis_q, axis_d;
  logic         cur_conv_w;

  assign cur_conv_w = conv_i[axis_q];

  always_comb begin
    state_d = state_q;
    axis_d  = axis_q;
    init_o  = 1'b0;
    step_o  = 1'b0;
    upd_o   = 1'b0;
    fix_o   = 1'b0;
    unique case (state_q)
      PS_IDLE, PS_DONE: begin
        if (start_i) begin
          init_o  = 1'b1;
          axis_d  = AX_HEAD;
          state_d = PS_CHECK;
        end
      end
      PS_CHECK: begin
        if (cur_conv_w) begin
          state_d = PS_FIX;
        end else begin
          step_o  = 1'b1;
          state_d = PS_ISSUE;
        end
      end
      PS_ISSUE: state_d = PS_WAIT;
      PS_WAIT: begin
        if (rsp_valid_i) begin
          upd_o   = 1'b1;
          state_d = PS_CHECK;
        end
      end
      PS_FIX: begin
        fix_o = 1'b1;
        if (axis_q == LAST_AXIS) begin
          state_d = PS_DONE;
        end else begin
          axis_d  = axis_q + axis_idx_t'(1);
          state_d = PS_CHECK;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      axis_q  <= AX_HEAD;
    end else begin
      state_q <= state_d;
      axis_q  <= axis_d;
    end
  end

  assign axis_o = axis_q;
  assign req_o  = (state_q == PS_ISSUE);
  assign busy_o = (state_q != PS_IDLE) && (state_q != PS_DONE);
  assign done_o = (state_q == PS_DONE);

endmodule

// File: rtl/geom_prober.sv
module geom_prober
  import geom_probe_pkg::*;
#(
  parameter int HEAD_LIMIT = 16,
  parameter int CYL_LIMIT  = 1024,
  parameter int SEC_LIMIT  = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  output logic                            req_valid_o,
  output logic [7:0]                      req_opcode_o,
  output logic [$clog2(HEAD_LIMIT+1)-1:0] req_head_o,
  output logic [$clog2(CYL_LIMIT+1)-1:0]  req_cyl_o,
  output logic [$clog2(SEC_LIMIT+1)-1:0]  req_sec_o,
  input  logic                            rsp_valid_i,
  input  logic                            rsp_ok_i,
  input  logic                            rsp_timeout_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic [$clog2(HEAD_LIMIT+1)-1:0] geo_heads_o,
  output logic [$clog2(CYL_LIMIT+1)-1:0]  geo_cyls_o,
  output logic [$clog2(SEC_LIMIT+1)-1:0]  geo_secs_o,
  output logic [7:0]                      geo_ctrl_o
);

  localparam int HBW = $clog2(HEAD_LIMIT + 1);
  localparam int CBW = $clog2(CYL_LIMIT + 1);
  localparam int SBW = $clog2(SEC_LIMIT + 1);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  axis_idx_t           axis_w;
  logic                init_w, step_w, upd_w, fix_w;
  logic                ok_eff_w;
  logic [NUM_AXES-1:0] conv_w;
  logic [NUM_AXES-1:0] sel_w;
  logic [HBW-1:0]      h_probe_w, h_low_w;
  logic [CBW-1:0]      c_probe_w, c_low_w;
  logic [SBW-1:0]      s_probe_w, s_low_w;

  // a transport timeout always counts as a rejected seek
  assign ok_eff_w = rsp_ok_i & ~rsp_timeout_i;

  for (genvar i = 0; i < NUM_AXES; i++) begin : g_sel
    assign sel_w[i] = (axis_w == axis_idx_t'(i));
  end

  probe_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .rsp_valid_i (rsp_valid_i),
    .conv_i      (conv_w),
    .axis_o      (axis_w),
    .init_o      (init_w),
    .step_o      (step_w),
    .upd_o       (upd_w),
    .fix_o       (fix_w),
    .req_o       (req_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  bisect_axis #(.MAXV(HEAD_LIMIT), .BW(HBW)) u_head (
    .clk (clk), .rst_n (rst_int_n), .init_i (init_w), .sel_i (sel_w[AX_HEAD]),
    .step_i (step_w), .upd_i (upd_w), .ok_i (ok_eff_w), .fix_i (fix_w),
    .probe_o (h_probe_w), .low_o (h_low_w), .conv_o (conv_w[AX_HEAD])
  );

  bisect_axis #(.MAXV(CYL_LIMIT), .BW(CBW)) u_cyl (
    .clk (clk), .rst_n (rst_int_n), .init_i (init_w), .sel_i (sel_w[AX_CYL]),
    .step_i (step_w), .upd_i (upd_w), .ok_i (ok_eff_w), .fix_i (fix_w),
    .probe_o (c_probe_w), .low_o (c_low_w), .conv_o (conv_w[AX_CYL])
  );

  bisect_axis #(.MAXV(SEC_LIMIT), .BW(SBW)) u_sec (
    .clk (clk), .rst_n (rst_int_n), .init_i (init_w), .sel_i (sel_w[AX_SEC]),
    .step_i (step_w), .upd_i (upd_w), .ok_i (ok_eff_w), .fix_i (fix_w),
    .probe_o (s_probe_w), .low_o (s_low_w), .conv_o (conv_w[AX_SEC])
  );

  assign req_opcode_o = SEEK_OPCODE;
  assign req_head_o   = h_probe_w;
  assign req_cyl_o    = c_probe_w;
  assign req_sec_o    = s_probe_w;

  assign geo_heads_o  = h_low_w + HBW'(1);
  assign geo_cyls_o   = c_low_w + CBW'(1);
  assign geo_secs_o   = s_low_w + SBW'(1);
  assign geo_ctrl_o   = 8'h00;

  // R7: the request strobe never lasts two cycles
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid_o |=> !req_valid_o);

  // R7: a request is only raised inside a search
  p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid_o |-> busy_o && !done_o);

  // R7: fields of the outstanding request hold into the wait
  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid_o |=> $stable({req_head_o, req_cyl_o, req_sec_o}));

  // R9: done and the geometry hold until a new start
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !start_i) |=> done_o && $stable({geo_heads_o, geo_cyls_o, geo_secs_o}));

endmodule

// File: tb/geom_prober_tb_top.sv
module geom_prober_tb_top;

  localparam int HL = 16;
  localparam int CL = 1024;
  localparam int SL = 64;
  localparam int HSTEPS = $clog2(HL);
  localparam int CSTEPS = $clog2(CL);
  localparam int SSTEPS = $clog2(SL);
  localparam int NREQ = HSTEPS + CSTEPS + SSTEPS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic       req_valid_o;
  logic [7:0] req_opcode_o;
  logic [4:0] req_head_o;
  logic [10:0] req_cyl_o;
  logic [6:0] req_sec_o;
  logic       rsp_valid_i, rsp_ok_i, rsp_timeout_i;
  logic       busy_o, done_o;
  logic [4:0] geo_heads_o;
  logic [10:0] geo_cyls_o;
  logic [6:0] geo_secs_o;
  logic [7:0] geo_ctrl_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  geom_prober #(.HEAD_LIMIT(HL), .CYL_LIMIT(CL), .SEC_LIMIT(SL)) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .req_valid_o (req_valid_o), .req_opcode_o (req_opcode_o),
    .req_head_o (req_head_o), .req_cyl_o (req_cyl_o), .req_sec_o (req_sec_o),
    .rsp_valid_i (rsp_valid_i), .rsp_ok_i (rsp_ok_i), .rsp_timeout_i (rsp_timeout_i),
    .busy_o (busy_o), .done_o (done_o),
    .geo_heads_o (geo_heads_o), .geo_cyls_o (geo_cyls_o), .geo_secs_o (geo_secs_o),
    .geo_ctrl_o (geo_ctrl_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int clampv(input int v, input int m);
    if (v < 1) return 1;
    if (v > m) return m;
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // one full search against a drive that accepts head<h, cyl<c, sec<s
  task automatic run_probe(input int h, input int c, input int s,
                           input bit tmo, input bit poke);
    int hh, eh, ec, es, nreq, cyc, qh, qc, qs;
    bit acc, acc1;
    hh = tmo ? 0 : h;
    eh = (c >= 1 && s >= 1) ? clampv(hh, HL) : 1;
    ec = ((eh - 1) < hh && s >= 1) ? clampv(c, CL) : 1;
    es = ((eh - 1) < hh && (ec - 1) < c) ? clampv(s, SL) : 1;
    acc1 = (HL / 2 < hh) && c >= 1 && s >= 1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R9", "busy after start", int'(busy_o), 1);
    chk("R9", "done cleared by start", int'(done_o), 0);
    nreq = 0;
    cyc = 0;
    while (!done_o && cyc < 4000) begin
      if (req_valid_o) begin
        nreq++;
        qh = int'(req_head_o);
        qc = int'(req_cyl_o);
        qs = int'(req_sec_o);
        chk("R2", "opcode", int'(req_opcode_o), 8'h0B);
        if (nreq <= HSTEPS) begin
          chk("R2", "cyl during head search", qc, 0);
          chk("R2", "sec during head search", qs, 0);
          if (nreq == 1) chk("R3", "first head probe", qh, HL / 2);
          if (nreq == 2) chk("R3", "second head probe", qh, acc1 ? (HL / 2 + HL) / 2 : HL / 4);
        end else if (nreq <= HSTEPS + CSTEPS) begin
          chk("R2", "head during cyl search", qh, eh - 1);
          chk("R2", "sec during cyl search", qs, 0);
          if (nreq == HSTEPS + 1) chk("R3", "first cyl probe", qc, CL / 2);
        end else begin
          chk("R2", "head during sec search", qh, eh - 1);
          chk("R2", "cyl during sec search", qc, ec - 1);
          if (nreq == HSTEPS + CSTEPS + 1) chk("R3", "first sec probe", qs, SL / 2);
        end
        acc = (qh < h) && (qc < c) && (qs < s);
        @(negedge clk);
        cyc++;
        chk("R7", "strobe width", int'(req_valid_o), 0);
        if (poke && nreq == 3) start_i = 1'b1;
        for (int d = 0; d < nreq % 3; d++) begin
          @(negedge clk);
          cyc++;
          start_i = 1'b0;
          if (req_valid_o) chk("R7", "request before response", 1, 0);
        end
        rsp_valid_i   = 1'b1;
        rsp_ok_i      = tmo ? 1'b1 : acc;
        rsp_timeout_i = tmo;
        @(negedge clk);
        cyc++;
        rsp_valid_i   = 1'b0;
        rsp_ok_i      = 1'b0;
        rsp_timeout_i = 1'b0;
        start_i       = 1'b0;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    chk("R4", "search finished in time", int'(done_o), 1);
    chk("R4", "request count", nreq, NREQ);
    chk("R5", "heads", int'(geo_heads_o), eh);
    chk("R5", "cylinders", int'(geo_cyls_o), ec);
    chk("R5", "sectors", int'(geo_secs_o), es);
    chk("R5", "control byte", int'(geo_ctrl_o), 0);
    chk("R9", "busy low when done", int'(busy_o), 0);
    repeat (4) @(negedge clk);
    chk("R9", "done held", int'(done_o), 1);
    chk("R9", "heads held", int'(geo_heads_o), eh);
    chk("R9", "sectors held", int'(geo_secs_o), es);
  endtask

  function automatic int cyl_pick(input int i);
    case (i % 9)
      0: return 1;
      1: return 2;
      2: return 511;
      3: return 512;
      4: return 513;
      5: return 1000;
      6: return 1023;
      7: return 1024;
      default: return 1025;
    endcase
  endfunction

  function automatic int sec_pick(input int i);
    case (i % 7)
      0: return 17;
      1: return 1;
      2: return 63;
      3: return 64;
      4: return 33;
      5: return 32;
      default: return 70;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    rsp_valid_i = 1'b0;
    rsp_ok_i = 1'b0;
    rsp_timeout_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done after reset", int'(done_o), 0);
    chk("R1", "busy after reset", int'(busy_o), 0);
    chk("R1", "request after reset", int'(req_valid_o), 0);
    repeat (5) begin
      @(negedge clk);
      if (req_valid_o) chk("R1", "request without start", 1, 0);
    end

    // heads from none to beyond the limit; R10 at h=0, R8 start poke at h=5
    for (int h = 0; h <= HL + 1; h++) run_probe(h, cyl_pick(h), sec_pick(h), 1'b0, h == 5);
    // cylinders and sectors around the edges
    for (int i = 0; i < 14; i++) run_probe(1 + (i * 5) % HL, cyl_pick(i), sec_pick(i + 3), 1'b0, 1'b0);
    // R10: a zero dimension rejects everything
    run_probe(7, 0, 20, 1'b0, 1'b0);
    run_probe(7, 300, 0, 1'b0, 1'b0);
    // R6: timeouts with success also high
    run_probe(HL, CL, SL, 1'b1, 1'b0);
    run_probe(3, 100, 17, 1'b1, 1'b1);

    // R8: stray responses after the search leave everything as it is
    run_probe(4, 615, 17, 1'b0, 1'b0);
    @(negedge clk);
    rsp_valid_i = 1'b1;
    rsp_ok_i    = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (req_valid_o) chk("R8", "request from stray response", 1, 0);
    end
    rsp_valid_i = 1'b0;
    rsp_ok_i    = 1'b0;
    rsp_timeout_i = 1'b1;
    @(negedge clk);
    rsp_valid_i = 1'b1;
    @(negedge clk);
    rsp_valid_i = 1'b0;
    rsp_timeout_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "heads after stray responses", int'(geo_heads_o), 4);
    chk("R8", "cylinders after stray responses", int'(geo_cyls_o), 615);
    chk("R8", "sectors after stray responses", int'(geo_secs_o), 17);
    chk("R8", "done after stray responses", int'(done_o), 1);

    // R9: restart from the initial bounds
    run_probe(HL, CL, SL, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule